// File: doc/BRIEF.md
# Byte-Stream Video Output Engine

This block moves the contents of a local byte buffer onto an 8-bit output bus, one byte per clock, exactly as stored. A control write carries an enable bit and two mode bits. One mode bit chooses between continuous streaming and message transfer. The other turns on a data-valid indication for streaming. Two sideband strobes frame the transfer. In streaming mode the first strobe gives a one-cycle warning before the data starts and the second marks the data-valid window. In message mode the two strobes mark the start and the end of the message, and the end of a message also sets the buffer-empty flag and raises a held interrupt.

The buffer is read through an address output and a combinational data input. The byte count is captured when the transfer starts. An error input stops a stream at once. A control write that clears the enable bit stops a transfer in either mode. After a transfer ends, the engine stays idle until a new enabling write arrives. Software acknowledges the interrupt by pulsing a write-one-to-clear input.

Top module: `vid_byte_out`

## Requirements
- R1: While the synchronous active-high reset is applied, vo_data is 0x00, vo_io1 and vo_io2 are low, buf_empty is high and irq is low.
- R2: A control write with ctl_enable=1 starts a transfer. vo_io1 is high for exactly the one cycle after that write edge and is low otherwise.
- R3: Byte i (0 <= i < count) of the buffer appears unchanged on vo_data in the i+2-th cycle after the start write, with buf_rd_addr = i at the edge that loads it. Bytes go out in ascending address order with no gaps.
- R4: In streaming mode (ctl_msg=0) with ctl_sync=1, vo_io2 is high in exactly the cycles that carry a valid byte. With ctl_sync=0, vo_io2 stays low in streaming mode.
- R5: In streaming mode, err_in high at an edge ends the transfer there. The next cycle shows vo_io2 low and vo_data 0x00, and no further bytes follow. err_in has no effect in message mode or while idle.
- R6: A control write with ctl_enable=0 during a transfer stops it at that edge. The next cycle shows vo_io2 low and vo_data 0x00, and buf_empty is set.
- R7: In message mode (ctl_msg=1), vo_io2 stays low while bytes are sent. It then pulses high for one cycle in the cycle right after the last byte.
- R8: When a message completes, buf_empty and irq rise in the same cycle as the end pulse. irq then stays high until irq_ack is sampled high, and it is low from the next cycle on.
- R9: buf_empty falls in the cycle after a start write and rises when a transfer completes or is stopped. Once idle, the engine drives no byte and no strobe, whatever the buffer contents or err_in, until the next enabling write.
- R10: vo_data is 0x00 in every cycle that does not carry a valid byte.
- R11: A byte count of zero sends no byte. In message mode the end pulse then follows the start pulse in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output byte clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ctl_we | input | 1 | Control write strobe |
| ctl_enable | input | 1 | Enable bit of the control write |
| ctl_msg | input | 1 | 1 = message mode, 0 = streaming mode |
| ctl_sync | input | 1 | Data-valid indication on vo_io2 in streaming mode |
| irq_ack | input | 1 | Write-one-to-clear acknowledge for irq |
| err_in | input | 1 | Error signal; stops a stream |
| buf_len | input | ADDR_W+1 | Byte count, captured at the start write |
| buf_rd_addr | output | ADDR_W | Buffer read address |
| buf_rd_data | input | 8 | Buffer read data, valid in the same cycle as the address |
| vo_data | output | 8 | Output byte bus |
| vo_io1 | output | 1 | Sideband strobe 1: start pulse |
| vo_io2 | output | 1 | Sideband strobe 2: data-valid in streaming, end pulse in messages |
| buf_empty | output | 1 | Buffer-empty status flag |
| irq | output | 1 | Completion interrupt, held until acknowledged |

## Verification
Every output is registered once, so each result is due a fixed number of edges after its cause. The start pulse comes one edge after the write. Byte i comes i+1 edges after the start pulse. The end pulse, buf_empty and irq come one edge after the last byte. An abort shows one edge after the error or disabling write, and irq falls one edge after the acknowledge. The bench drives inputs on the falling edge and advances a queue-based reference model on each rising edge. It compares all five observable outputs against that model at the next falling edge, so every due result is checked in exactly the cycle it belongs to.

// File: rtl/vbo_pkg.sv
package vbo_pkg;

  // Per-cycle events decided by the sequencer, shared with the output stage,
  // the status flags and the checker.
  typedef struct packed {
    logic start;    // enabling control write accepted
    logic byte_ok;  // a buffer byte is loaded onto the bus at this edge
    logic finish;   // count reached: transfer completes at this edge
    logic abort;    // error or disabling write ends the transfer
  } vbo_ev_t;

endpackage

// File: rtl/vbo_ctrl.sv
module vbo_ctrl #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic              ctl_enable,
  input  logic              ctl_msg,
  input  logic              ctl_sync,
  input  logic              err_in,
  input  logic [ADDR_W:0]   buf_len,
  output logic [ADDR_W-1:0] rd_addr,
  output vbo_pkg::vbo_ev_t  ev,
  output logic              msg_q,
  output logic              sync_q
);

  localparam int CNT_W = ADDR_W + 1;

  logic             busy_q;
  logic [CNT_W-1:0] idx_q;
  logic [CNT_W-1:0] len_q;
  logic             sw_start;
  logic             sw_stop;
  logic             fault;
  logic             step;
  logic             more;

  function automatic logic bytes_remain(input logic [CNT_W-1:0] pos,
                                        input logic [CNT_W-1:0] total);
    return pos < total;
  endfunction

  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] pos);
    return pos + CNT_W'(1);
  endfunction

  assign sw_start = ctl_we & ctl_enable;
  assign sw_stop  = ctl_we & ~ctl_enable & busy_q;
  assign fault    = busy_q & ~ctl_we & ~msg_q & err_in;
  assign step     = busy_q & ~ctl_we & ~fault;
  assign more     = bytes_remain(idx_q, len_q);

  assign ev.start   = sw_start;
  assign ev.byte_ok = step & more;
  assign ev.finish  = step & ~more;
  assign ev.abort   = sw_stop | fault;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      len_q  <= '0;
      msg_q  <= 1'b0;
      sync_q <= 1'b0;
    end else if (sw_start) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      len_q  <= buf_len;
      msg_q  <= ctl_msg;
      sync_q <= ctl_sync;
    end else if (ev.finish || ev.abort) begin
      busy_q <= 1'b0;
    end else if (ev.byte_ok) begin
      idx_q  <= advance(idx_q);
    end
  end

  assign rd_addr = idx_q[ADDR_W-1:0];

endmodule

// File: rtl/vbo_out.sv
module vbo_out #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  vbo_pkg::vbo_ev_t  ev,
  input  logic              msg_q,
  input  logic              sync_q,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] vo_data,
  output logic              vo_io1,
  output logic              vo_io2
);

  logic stream_valid;
  logic msg_end;

  assign stream_valid = ev.byte_ok & ~msg_q & sync_q;
  assign msg_end      = ev.finish & msg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vo_data <= '0;
      vo_io1  <= 1'b0;
      vo_io2  <= 1'b0;
    end else begin
      vo_data <= ev.byte_ok ? rd_data : '0;
      vo_io1  <= ev.start;
      vo_io2  <= stream_valid | msg_end;
    end
  end

endmodule

// File: rtl/vbo_status.sv
module vbo_status (
  input  logic             clk,
  input  logic             rst,
  input  vbo_pkg::vbo_ev_t ev,
  input  logic             msg_q,
  input  logic             irq_ack,
  output logic             buf_empty,
  output logic             irq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_empty <= 1'b1;
      irq       <= 1'b0;
    end else begin
      if (ev.start)                    buf_empty <= 1'b0;
      else if (ev.finish || ev.abort)  buf_empty <= 1'b1;

      if (ev.finish && msg_q)          irq <= 1'b1;
      else if (irq_ack)                irq <= 1'b0;
    end
  end

endmodule

// File: rtl/vid_byte_out.sv
module vid_byte_out #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic              ctl_enable,
  input  logic              ctl_msg,
  input  logic              ctl_sync,
  input  logic              irq_ack,
  input  logic              err_in,
  input  logic [ADDR_W:0]   buf_len,
  output logic [ADDR_W-1:0] buf_rd_addr,
  input  logic [DATA_W-1:0] buf_rd_data,
  output logic [DATA_W-1:0] vo_data,
  output logic              vo_io1,
  output logic              vo_io2,
  output logic              buf_empty,
  output logic              irq
);

  vbo_pkg::vbo_ev_t ev;
  logic             msg_q;
  logic             sync_q;

  vbo_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .ctl_we     (ctl_we),
    .ctl_enable (ctl_enable),
    .ctl_msg    (ctl_msg),
    .ctl_sync   (ctl_sync),
    .err_in     (err_in),
    .buf_len    (buf_len),
    .rd_addr    (buf_rd_addr),
    .ev         (ev),
    .msg_q      (msg_q),
    .sync_q     (sync_q)
  );

  vbo_out #(.DATA_W(DATA_W)) out_i (
    .clk     (clk),
    .rst     (rst),
    .ev      (ev),
    .msg_q   (msg_q),
    .sync_q  (sync_q),
    .rd_data (buf_rd_data),
    .vo_data (vo_data),
    .vo_io1  (vo_io1),
    .vo_io2  (vo_io2)
  );

  vbo_status status_i (
    .clk       (clk),
    .rst       (rst),
    .ev        (ev),
    .msg_q     (msg_q),
    .irq_ack   (irq_ack),
    .buf_empty (buf_empty),
    .irq       (irq)
  );

endmodule

// File: rtl/vbo_chk.sv
module vbo_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              irq_ack,
  input logic [DATA_W-1:0] buf_rd_data,
  input logic [DATA_W-1:0] vo_data,
  input logic              vo_io1,
  input logic              vo_io2,
  input logic              buf_empty,
  input logic              irq,
  input vbo_pkg::vbo_ev_t  ev,
  input logic              msg_q,
  input logic              sync_q
);

  a_r2_start_pulse: assert property (@(posedge clk) disable iff (rst)
    ev.start |=> vo_io1);

  a_r2_no_stray_io1: assert property (@(posedge clk) disable iff (rst)
    !ev.start |=> !vo_io1);

  a_r3_byte_passthru: assert property (@(posedge clk) disable iff (rst)
    ev.byte_ok |=> (vo_data == $past(buf_rd_data)));

  a_r10_bus_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !ev.byte_ok |=> (vo_data == '0));

  a_r4_valid_window: assert property (@(posedge clk) disable iff (rst)
    (ev.byte_ok && !msg_q && sync_q) |=> vo_io2);

  a_r5_abort_drops_io2: assert property (@(posedge clk) disable iff (rst)
    ev.abort |=> (!vo_io2 && buf_empty));

  a_r7_end_marks: assert property (@(posedge clk) disable iff (rst)
    (ev.finish && msg_q) |=> (vo_io2 && buf_empty && irq));

  a_r8_irq_held: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_ack) |=> irq);

  a_r8_irq_cleared: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !(ev.finish && msg_q)) |=> !irq);

  a_r9_start_clears_empty: assert property (@(posedge clk) disable iff (rst)
    ev.start |=> !buf_empty);

endmodule

bind vid_byte_out vbo_chk #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .irq_ack     (irq_ack),
  .buf_rd_data (buf_rd_data),
  .vo_data     (vo_data),
  .vo_io1      (vo_io1),
  .vo_io2      (vo_io2),
  .buf_empty   (buf_empty),
  .irq         (irq),
  .ev          (ev),
  .msg_q       (msg_q),
  .sync_q      (sync_q)
);

// File: tb/vid_byte_out_tb_top.sv
module vid_byte_out_tb_top;

  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ctl_we = 1'b0, ctl_enable = 1'b0, ctl_msg = 1'b0, ctl_sync = 1'b0;
  logic          irq_ack = 1'b0, err_in = 1'b0;
  logic [AW:0]   buf_len = '0;
  logic [AW-1:0] buf_rd_addr;
  logic [7:0]    buf_rd_data;
  logic [7:0]    vo_data;
  logic          vo_io1, vo_io2, buf_empty, irq;

  logic [7:0]    mem [256];
  assign buf_rd_data = mem[buf_rd_addr];

  always #10 clk = ~clk;

  vid_byte_out #(.ADDR_W(AW), .DATA_W(8)) dut_i (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_enable(ctl_enable),
    .ctl_msg(ctl_msg), .ctl_sync(ctl_sync), .irq_ack(irq_ack), .err_in(err_in),
    .buf_len(buf_len), .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data),
    .vo_data(vo_data), .vo_io1(vo_io1), .vo_io2(vo_io2),
    .buf_empty(buf_empty), .irq(irq)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  bit    live = 1'b0;
  string scen = "R1";

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", tag, scen, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Behavioural reference: a queue of pending bytes and expected outputs.
  logic [7:0] q [$];
  bit         m_busy = 0, m_msg = 0, m_sync = 0;
  logic [7:0] e_data = 0;
  bit         e_io1 = 0, e_io2 = 0, e_empty = 1, e_irq = 0;

  always @(posedge clk) begin
    bit nirq;
    if (rst) begin
      m_busy = 0; e_data = 0; e_io1 = 0; e_io2 = 0; e_empty = 1; e_irq = 0;
      q.delete();
    end else begin
      nirq = e_irq;
      if (irq_ack) nirq = 0;
      e_io1 = 0; e_io2 = 0; e_data = 0;
      if (ctl_we && ctl_enable) begin
        m_busy = 1; m_msg = ctl_msg; m_sync = ctl_sync;
        q.delete();
        for (int i = 0; i < int'(buf_len); i++) q.push_back(mem[i]);
        e_io1 = 1; e_empty = 0;
      end else if (ctl_we) begin
        if (m_busy) e_empty = 1;
        m_busy = 0;
      end else if (m_busy) begin
        if (!m_msg && err_in) begin
          m_busy = 0; e_empty = 1;
        end else if (q.size() > 0) begin
          e_data = q.pop_front();
          e_io2 = !m_msg && m_sync;
        end else begin
          m_busy = 0; e_empty = 1;
          if (m_msg) begin e_io2 = 1; nirq = 1; end
        end
      end
      e_irq = nirq;
    end
  end

  always @(negedge clk) begin
    if (live && !done) begin
      check("R3/R10 vo_data", int'(vo_data), int'(e_data));
      check("R2 vo_io1", int'(vo_io1), int'(e_io1));
      check("R4/R7 vo_io2", int'(vo_io2), int'(e_io2));
      check("R9 buf_empty", int'(buf_empty), int'(e_empty));
      check("R8 irq", int'(irq), int'(e_irq));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit en, bit m, bit s, int len);
    @(negedge clk);
    ctl_we = 1; ctl_enable = en; ctl_msg = m; ctl_sync = s; buf_len = len[AW:0];
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic fill(int seed);
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + seed * 11 + 1) ^ (i >> 3));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired, actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    int ones;
    fill(0);
    cyc(3);
    // R1: reset state at the ports
    check("R1 vo_data", int'(vo_data), 0);
    check("R1 vo_io1", int'(vo_io1), 0);
    check("R1 vo_io2", int'(vo_io2), 0);
    check("R1 buf_empty", int'(buf_empty), 1);
    check("R1 irq", int'(irq), 0);
    live = 1;
    rst = 0;
    cyc(2);

    scen = "R4 stream sync"; wr(1, 0, 1, 5); cyc(8);
    scen = "R4 stream nosync"; fill(3); wr(1, 0, 0, 3); cyc(6);

    scen = "R7 msg"; fill(5); wr(1, 1, 0, 4); cyc(10);
    check("R8 irq held", int'(irq), 1);
    irq_ack = 1; cyc(1); irq_ack = 0; cyc(1);
    check("R8 irq cleared", int'(irq), 0);

    scen = "R11 msg len0"; wr(1, 1, 1, 0); cyc(4);
    irq_ack = 1; cyc(1); irq_ack = 0;
    scen = "R11 stream len0"; wr(1, 0, 1, 0); cyc(4);

    scen = "R5 stream err"; fill(7); wr(1, 0, 1, 20); cyc(5);
    err_in = 1; cyc(1); err_in = 0; cyc(25);
    scen = "R5 msg err ignored"; wr(1, 1, 0, 6); cyc(2);
    err_in = 1; cyc(2); err_in = 0; cyc(8);
    irq_ack = 1; cyc(1); irq_ack = 0;

    scen = "R6 disable stream"; wr(1, 0, 1, 20); cyc(4); wr(0, 0, 1, 20); cyc(25);
    scen = "R6 disable msg"; wr(1, 1, 0, 20); cyc(3); wr(0, 1, 0, 20); cyc(25);
    check("R6 no irq after abort", int'(irq), 0);

    scen = "R9 idle ignores"; fill(9); err_in = 1; cyc(4); err_in = 0;
    ones = 0;
    for (int k = 0; k < 10; k++) begin
      cyc(1);
      if (vo_io1 || vo_io2 || vo_data != 0) ones++;
    end
    check("R9 idle quiet", ones, 0);

    scen = "R2 back to back"; wr(1, 0, 1, 3); wr(1, 1, 0, 2); cyc(6);
    irq_ack = 1; cyc(1); irq_ack = 0;
    scen = "R3 full buffer"; fill(11); wr(1, 0, 1, 256); cyc(262);
    scen = "R8 ack same cycle"; wr(1, 1, 1, 2); cyc(2); irq_ack = 1; cyc(1); irq_ack = 0; cyc(3);
    check("R8 set wins over ack", int'(irq), 1);

    cyc(2);
    done = 1;
    report();
    $finish;
  end

endmodule